// File: doc/BRIEF.md
# Codec Control-Port Write Sequencer

This block owns the three-wire serial control port of an audio codec: an active-low select, a serial clock and a serial data line, plus the codec's active-low reset pin. A host presents a 7-bit register address and a value on a command port. The block packs them into one 16-bit frame, shifts that frame out, and then signals completion with a single-cycle pulse. A shadow copy of every codec register is kept on chip, so the host can read back the last value it wrote without any read traffic on the wire.

When the block leaves reset, it brings the codec up without help from the host. It first holds the codec in reset, then lifts the select line, and then releases the reset. After a settling wait, it streams a fixed initialization list from an internal table. The output and input routing registers are written before the codec is powered up, which keeps turn-on pops down. Only once that list has finished does the block accept host commands.

A host write either records its value in the shadow (cached write) or leaves the shadow untouched (uncached write). The uncached form suits a second "update" write that repeats a value already latched by an earlier cached write.

Top module: `codec_ctl_seq`

## Requirements
- R1: A frame carries the register address in bits 15:9 and the value in bits 8:0. Bits 15:9 of the 16-bit `cmdData` input are ignored.
- R2: Each frame is exactly 16 bits, sent most significant bit first. The codec samples one bit on each rising edge of `codecSclk` while `codecCsN` is low.
- R3: For every bit, `codecSclk` goes low and the data line takes the new bit during that low half. Then `codecSclk` rises. `codecSdat` never changes while `codecSclk` stays high. One serial clock period lasts `CLK_DIV` system cycles, with `CLK_DIV/2` cycles low and `CLK_DIV/2` cycles high.
- R4: `codecCsN` is low for the whole frame and rises `CLK_DIV/2` cycles after the last rising clock edge. It then stays high for at least `2*CLK_DIV` cycles before the next frame starts. `codecSclk` idles high whenever `codecCsN` is high.
- R5: While `rstN` is low, the outputs are `codecRstN`=0, `codecCsN`=0, `codecSclk`=1 and `busy`=1. After reset, `codecCsN` rises while `codecRstN` is still low. Both stay in that state for `RST_LOW_CYC` cycles. Then `codecRstN` rises, and the first frame starts `RST_WAIT_CYC` cycles later. No clock edge is sent while `codecRstN` is low.
- R6: The power-on list is 30 cached writes, given as (address, value), in this order: (1B,044) (1C,00B) (1D,009), then (18,000), then (16,122) (17,022). Next come registers 00 to 07 with 000, register 08 with 100, registers 09 to 10 with 0FF, and register 11 with 1FF. The list ends with (12,000) (13,090) (14,000) (15,000) (19,000) (1A,000).
- R7: All shadow entries read zero after reset. In the cycle where `done` pulses, `rdData` at a cached write's address returns the frame's 9-bit value.
- R8: An uncached write (`cmdNoCache`=1) sends its frame, but the shadow entry keeps its previous value.
- R9: `cmdAccept` goes high only when `cmdValid` is high, `busy` is low and `initDone` is high. Commands that are not accepted produce no frame and change no shadow entry.
- R10: `done` pulses for one cycle after each host frame, once the post-frame select gap has elapsed. `busy` is low in that cycle. Initialization frames raise no `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdValid | input | 1 | Host presents a write command |
| cmdAddr | input | 7 | Codec register address |
| cmdData | input | 16 | Value; only bits 8:0 are used |
| cmdNoCache | input | 1 | 1 = send without updating the shadow |
| cmdAccept | output | 1 | Command taken this cycle |
| busy | output | 1 | Sequencer occupied (power-on, init or frame) |
| done | output | 1 | One-cycle pulse after a host frame completes |
| initDone | output | 1 | Power-on list finished |
| rdAddr | input | 7 | Shadow read address |
| rdData | output | 9 | Shadow value at `rdAddr` |
| codecCsN | output | 1 | Control-port select, active low |
| codecSclk | output | 1 | Control-port serial clock |
| codecSdat | output | 1 | Control-port serial data |
| codecRstN | output | 1 | Codec reset, active low |

## Verification
The serializer is driven with frames whose patterns separate distinct faults. The all-ones frame and the alternating 0x5555/0xAAAA frames expose bit-order reversal and off-by-one shifting. A frame with nonzero upper `cmdData` bits shows whether those bits leak into the address field. The shadow is checked with a cached write followed by an uncached write to the same address, which separates the two write kinds. The thirty power-on frames are captured at the pins and compared in order, so any reordering of the routing and power writes is caught. Commands are also offered both during power-on and during a busy frame, to show they leave no trace on the wire or in the shadow.

// File: rtl/codec_seq_pkg.sv
package codec_seq_pkg;

  localparam int ADDR_W   = 7;
  localparam int VAL_W    = 9;
  localparam int FRAME_W  = ADDR_W + VAL_W;
  localparam int INIT_LEN = 30;
  localparam int IDX_W    = $clog2(INIT_LEN);
  localparam int BIT_W    = $clog2(FRAME_W);

  // Strobes from the sequencer control to the serial datapath.
  typedef struct packed {
    logic load;        // latch a new frame and start its first low half
    logic srcInit;     // frame comes from the power-on table
    logic sclkRise;    // drive the serial clock high
    logic shiftNext;   // advance to the next bit (clock low, new data)
    logic csHigh;      // release the select line
    logic rstRelease;  // release the codec reset
    logic commit;      // frame finished: update shadow, flag completion
  } seqStrobe_t;

  // Power-on table: routing first, then power, format, clocking, levels.
  function automatic logic [FRAME_W-1:0] initEntry(input int idx);
    logic [ADDR_W-1:0] a;
    logic [VAL_W-1:0]  v;
    a = '0;
    v = '0;
    if (idx == 0)                    begin a = 7'h1b; v = 9'h044; end
    else if (idx == 1)               begin a = 7'h1c; v = 9'h00b; end
    else if (idx == 2)               begin a = 7'h1d; v = 9'h009; end
    else if (idx == 3)               begin a = 7'h18; v = 9'h000; end
    else if (idx == 4)               begin a = 7'h16; v = 9'h122; end
    else if (idx == 5)               begin a = 7'h17; v = 9'h022; end
    else if (idx >= 6 && idx <= 13)  begin a = ADDR_W'(idx - 6); v = 9'h000; end
    else if (idx == 14)              begin a = 7'h08; v = 9'h100; end
    else if (idx >= 15 && idx <= 22) begin a = ADDR_W'(idx - 6); v = 9'h0ff; end
    else if (idx == 23)              begin a = 7'h11; v = 9'h1ff; end
    else if (idx >= 24 && idx <= 27) begin a = ADDR_W'(idx - 6); v = (idx == 25) ? 9'h090 : 9'h000; end
    else if (idx == 28)              begin a = 7'h19; v = 9'h000; end
    else if (idx == 29)              begin a = 7'h1a; v = 9'h000; end
    return {a, v};
  endfunction

endpackage

// File: rtl/codec_seq_ctrl.sv
module codec_seq_ctrl
  import codec_seq_pkg::*;
#(
  parameter int CLK_DIV      = 8,
  parameter int RST_LOW_CYC  = 16,
  parameter int RST_WAIT_CYC = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  output seqStrobe_t       strb,
  output logic [IDX_W-1:0] loadIdx,
  output logic             cmdAccept,
  output logic             busy,
  output logic             initDone
);

  localparam int HALF    = CLK_DIV / 2;
  localparam int GAP_CYC = 2 * CLK_DIV;
  localparam int MAX_A   = (RST_LOW_CYC > RST_WAIT_CYC) ? RST_LOW_CYC : RST_WAIT_CYC;
  localparam int MAX_C   = (MAX_A > GAP_CYC) ? MAX_A : GAP_CYC;
  localparam int CNT_W   = $clog2(MAX_C + 1);

  typedef enum logic [2:0] {
    S_RST_LOW, S_CS_UP, S_RST_WAIT, S_BIT_LOW, S_BIT_HIGH, S_GAP, S_IDLE
  } seqState_e;

  seqState_e         state, stNxt;
  logic [CNT_W-1:0]  cnt;
  logic [BIT_W-1:0]  bitIdx;
  logic [IDX_W-1:0]  romIdx;
  logic              inInit;
  logic              initDoneQ;
  logic              lastInit;

  assign lastInit = (romIdx == IDX_W'(INIT_LEN - 1));

  always_comb begin
    strb      = '0;
    stNxt     = state;
    cmdAccept = 1'b0;
    loadIdx   = '0;
    unique case (state)
      S_RST_LOW: if (cnt == CNT_W'(RST_LOW_CYC - 1)) begin
        strb.csHigh = 1'b1;
        stNxt       = S_CS_UP;
      end
      S_CS_UP: if (cnt == CNT_W'(RST_LOW_CYC - 1)) begin
        strb.rstRelease = 1'b1;
        stNxt           = S_RST_WAIT;
      end
      S_RST_WAIT: if (cnt == CNT_W'(RST_WAIT_CYC - 1)) begin
        strb.load    = 1'b1;
        strb.srcInit = 1'b1;
        stNxt        = S_BIT_LOW;
      end
      S_BIT_LOW: if (cnt == CNT_W'(HALF - 1)) begin
        strb.sclkRise = 1'b1;
        stNxt         = S_BIT_HIGH;
      end
      S_BIT_HIGH: if (cnt == CNT_W'(HALF - 1)) begin
        if (bitIdx == BIT_W'(FRAME_W - 1)) begin
          strb.csHigh = 1'b1;
          stNxt       = S_GAP;
        end else begin
          strb.shiftNext = 1'b1;
          stNxt          = S_BIT_LOW;
        end
      end
      S_GAP: if (cnt == CNT_W'(GAP_CYC - 1)) begin
        strb.commit = 1'b1;
        if (inInit && !lastInit) begin
          strb.load    = 1'b1;
          strb.srcInit = 1'b1;
          loadIdx      = romIdx + 1'b1;
          stNxt        = S_BIT_LOW;
        end else begin
          stNxt = S_IDLE;
        end
      end
      S_IDLE: if (cmdValid) begin
        cmdAccept = 1'b1;
        strb.load = 1'b1;
        stNxt     = S_BIT_LOW;
      end
      default: stNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_RST_LOW;
      cnt       <= '0;
      bitIdx    <= '0;
      romIdx    <= '0;
      inInit    <= 1'b1;
      initDoneQ <= 1'b0;
    end else begin
      state <= stNxt;
      if (stNxt != state || state == S_IDLE) cnt <= '0;
      else                                   cnt <= cnt + 1'b1;
      if (strb.load)           bitIdx <= '0;
      else if (strb.shiftNext) bitIdx <= bitIdx + 1'b1;
      if (strb.load && strb.srcInit) romIdx <= loadIdx;
      if (state == S_GAP && stNxt == S_IDLE && inInit) begin
        inInit    <= 1'b0;
        initDoneQ <= 1'b1;
      end
    end
  end

  assign busy     = (state != S_IDLE);
  assign initDone = initDoneQ;

endmodule

// File: rtl/codec_seq_shift.sv
module codec_seq_shift
  import codec_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic [IDX_W-1:0]  loadIdx,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [VAL_W-1:0]  cmdVal,
  input  logic              cmdNoCache,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [VAL_W-1:0]  rdData,
  output logic              codecCsN,
  output logic              codecSclk,
  output logic              codecSdat,
  output logic              codecRstN,
  output logic              done
);

  localparam int NUM_REGS = 1 << ADDR_W;

  logic [FRAME_W-1:0] frameNew;
  logic [FRAME_W-1:0] shreg;
  logic [ADDR_W-1:0]  curAddr;
  logic [VAL_W-1:0]   curVal;
  logic               curNoCache;
  logic               curHost;
  logic               wrEn;
  logic [VAL_W-1:0]   shadowQ [NUM_REGS];

  assign frameNew = strb.srcInit ? initEntry(int'(loadIdx)) : {cmdAddr, cmdVal};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shreg      <= '0;
      curAddr    <= '0;
      curVal     <= '0;
      curNoCache <= 1'b0;
      curHost    <= 1'b0;
      codecCsN   <= 1'b0;
      codecSclk  <= 1'b1;
      codecSdat  <= 1'b0;
      codecRstN  <= 1'b0;
      done       <= 1'b0;
    end else begin
      done <= strb.commit & curHost;
      if (strb.rstRelease) codecRstN <= 1'b1;
      if (strb.csHigh)     codecCsN  <= 1'b1;
      if (strb.sclkRise)   codecSclk <= 1'b1;
      if (strb.shiftNext) begin
        shreg     <= {shreg[FRAME_W-2:0], 1'b0};
        codecSdat <= shreg[FRAME_W-2];
        codecSclk <= 1'b0;
      end
      if (strb.load) begin
        shreg      <= frameNew;
        codecSdat  <= frameNew[FRAME_W-1];
        codecSclk  <= 1'b0;
        codecCsN   <= 1'b0;
        curAddr    <= frameNew[FRAME_W-1:VAL_W];
        curVal     <= frameNew[VAL_W-1:0];
        curNoCache <= strb.srcInit ? 1'b0 : cmdNoCache;
        curHost    <= ~strb.srcInit;
      end
    end
  end

  assign wrEn = strb.commit & ~curNoCache;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_shadow
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                 shadowQ[g] <= '0;
      else if (wrEn && curAddr == ADDR_W'(g))    shadowQ[g] <= curVal;
    end
  end

  assign rdData = shadowQ[rdAddr];

endmodule

// File: rtl/codec_ctl_seq.sv
module codec_ctl_seq
  import codec_seq_pkg::*;
#(
  parameter int CLK_DIV      = 8,
  parameter int RST_LOW_CYC  = 16,
  parameter int RST_WAIT_CYC = 24
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic [6:0]  cmdAddr,
  input  logic [15:0] cmdData,
  input  logic        cmdNoCache,
  output logic        cmdAccept,
  output logic        busy,
  output logic        done,
  output logic        initDone,
  input  logic [6:0]  rdAddr,
  output logic [8:0]  rdData,
  output logic        codecCsN,
  output logic        codecSclk,
  output logic        codecSdat,
  output logic        codecRstN
);

  seqStrobe_t       strb;
  logic [IDX_W-1:0] loadIdx;

  codec_seq_ctrl #(
    .CLK_DIV     (CLK_DIV),
    .RST_LOW_CYC (RST_LOW_CYC),
    .RST_WAIT_CYC(RST_WAIT_CYC)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .strb     (strb),
    .loadIdx  (loadIdx),
    .cmdAccept(cmdAccept),
    .busy     (busy),
    .initDone (initDone)
  );

  codec_seq_shift u_shift (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .loadIdx   (loadIdx),
    .cmdAddr   (cmdAddr),
    .cmdVal    (cmdData[VAL_W-1:0]),
    .cmdNoCache(cmdNoCache),
    .rdAddr    (rdAddr),
    .rdData    (rdData),
    .codecCsN  (codecCsN),
    .codecSclk (codecSclk),
    .codecSdat (codecSdat),
    .codecRstN (codecRstN),
    .done      (done)
  );

endmodule

// File: rtl/codec_ctl_seq_chk.sv
module codec_ctl_seq_chk (
  input logic clk,
  input logic rstN,
  input logic cmdAccept,
  input logic busy,
  input logic done,
  input logic initDone,
  input logic codecCsN,
  input logic codecSclk,
  input logic codecSdat,
  input logic codecRstN
);

  p_sdat_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (codecSclk && $past(codecSclk)) |-> $stable(codecSdat));

  p_sclk_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    codecCsN |-> codecSclk);

  p_no_clock_in_reset_r5: assert property (@(posedge clk) disable iff (!rstN)
    !codecRstN |-> (codecSclk && !initDone));

  p_accept_gate_r9: assert property (@(posedge clk) disable iff (!rstN)
    cmdAccept |-> (initDone && !busy));

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_after_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy) && initDone));

endmodule

bind codec_ctl_seq codec_ctl_seq_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cmdAccept(cmdAccept),
  .busy     (busy),
  .done     (done),
  .initDone (initDone),
  .codecCsN (codecCsN),
  .codecSclk(codecSclk),
  .codecSdat(codecSdat),
  .codecRstN(codecRstN)
);

// File: tb/codec_ctl_seq_bench.sv
module codec_ctl_seq_bench;

  localparam int CLK_DIV  = 8;
  localparam int RST_LOW  = 16;
  localparam int RST_WAIT = 24;
  localparam int HALF     = CLK_DIV / 2;
  localparam int NVEC     = 7;

  // {addr, cmdData, noCache, expected frame, expected shadow}
  localparam logic [48:0] VEC [NVEC] = '{
    {7'h20, 16'h0055, 1'b0, 16'h4055, 9'h055},
    {7'h20, 16'h01aa, 1'b1, 16'h41aa, 9'h055},
    {7'h7f, 16'hffff, 1'b0, 16'hffff, 9'h1ff},
    {7'h00, 16'hfe01, 1'b0, 16'h0001, 9'h001},
    {7'h2a, 16'h0155, 1'b0, 16'h5555, 9'h155},
    {7'h55, 16'h00aa, 1'b0, 16'haaaa, 9'h0aa},
    {7'h2a, 16'h0000, 1'b1, 16'h5400, 9'h155}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [6:0]  cmdAddr = '0;
  logic [15:0] cmdData = '0;
  logic        cmdNoCache = 1'b0;
  logic        cmdAccept, busy, done, initDone;
  logic [6:0]  rdAddr = '0;
  logic [8:0]  rdData;
  logic        codecCsN, codecSclk, codecSdat, codecRstN;

  codec_ctl_seq #(.CLK_DIV(CLK_DIV), .RST_LOW_CYC(RST_LOW), .RST_WAIT_CYC(RST_WAIT)) u_codec_ctl_seq (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdAddr(cmdAddr), .cmdData(cmdData),
    .cmdNoCache(cmdNoCache), .cmdAccept(cmdAccept), .busy(busy), .done(done),
    .initDone(initDone), .rdAddr(rdAddr), .rdData(rdData), .codecCsN(codecCsN),
    .codecSclk(codecSclk), .codecSdat(codecSdat), .codecRstN(codecRstN)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] expInit(input int i);
    logic [6:0] a;
    logic [8:0] v;
    case (i)
      0: begin a = 7'h1b; v = 9'h044; end
      1: begin a = 7'h1c; v = 9'h00b; end
      2: begin a = 7'h1d; v = 9'h009; end
      3: begin a = 7'h18; v = 9'h000; end
      4: begin a = 7'h16; v = 9'h122; end
      5: begin a = 7'h17; v = 9'h022; end
      14: begin a = 7'h08; v = 9'h100; end
      23: begin a = 7'h11; v = 9'h1ff; end
      24: begin a = 7'h12; v = 9'h000; end
      25: begin a = 7'h13; v = 9'h090; end
      26: begin a = 7'h14; v = 9'h000; end
      27: begin a = 7'h15; v = 9'h000; end
      28: begin a = 7'h19; v = 9'h000; end
      29: begin a = 7'h1a; v = 9'h000; end
      default: begin
        if (i >= 6 && i <= 13) begin a = 7'(i - 6); v = 9'h000; end
        else begin a = 7'(i - 6); v = 9'h0ff; end
      end
    endcase
    return {a, v};
  endfunction

  // Pin monitor, sampled on the falling system clock edge.
  logic        prevSclk = 1'b1, prevCs = 1'b0;
  logic [15:0] shiftIn = '0, lastFrame = '0;
  logic [15:0] initFrames [64];
  int bitCnt = 0, frames = 0, initCount = 0, lastRise = 0, lastCsRise = 0;
  int periodErr = 0, lagErr = 0, badBits = 0, holdErr = 0, minGap = 1000000;
  int csUpCycles = 0, waitCycles = 0, clockInReset = 0, doneInInit = 0;
  bit sawFrame = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (!codecRstN && codecCsN) csUpCycles++;
      if (codecRstN && codecCsN && !sawFrame) waitCycles++;
      if (!codecRstN && !codecSclk) clockInReset++;
      if (done && !initDone) doneInInit++;
      if (codecSclk && prevSclk && !codecCsN && codecSdat != shiftIn[0] && bitCnt > 0 && lastRise != cyc)
        holdErr += 0;
      if (codecSclk && !prevSclk && !codecCsN) begin
        if (bitCnt > 0 && (cyc - lastRise) != CLK_DIV) periodErr++;
        shiftIn = {shiftIn[14:0], codecSdat};
        bitCnt++;
        lastRise = cyc;
      end else if (codecSclk && prevSclk && !codecCsN && bitCnt > 0 && codecSdat != shiftIn[0]) begin
        holdErr++;
      end
      if (!codecCsN && prevCs && codecRstN) begin
        if (frames > 0 && (cyc - lastCsRise) < minGap) minGap = cyc - lastCsRise;
        sawFrame = 1;
      end
      if (codecCsN && !prevCs && bitCnt != 0) begin
        if (bitCnt != 16) badBits++;
        if ((cyc - lastRise) != HALF) lagErr++;
        lastFrame = shiftIn;
        frames++;
        if (!initDone && initCount < 64) begin
          initFrames[initCount] = shiftIn;
          initCount++;
        end
        lastCsRise = cyc;
        bitCnt = 0;
      end
      prevSclk = codecSclk;
      prevCs   = codecCsN;
    end
  end

  task automatic finish_run();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(negedge clk) begin
    if (cyc > 150000 && !finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      finish_run();
    end
  end

  task automatic readShadow(input logic [6:0] a, output logic [8:0] v);
    @(negedge clk);
    rdAddr = a;
    #1 v = rdData;
  endtask

  task automatic waitDone(output int lat, output bit busyAtDone, output bit widthOk);
    lat = 0;
    busyAtDone = 1;
    widthOk = 0;
    while (!done && lat < 2000) begin
      @(negedge clk);
      lat++;
    end
    busyAtDone = busy;
    @(negedge clk);
    widthOk = !done;
  endtask

  initial begin
    logic [8:0] sv;
    int lat;
    bit bad, wOk, accSeen;
    int mism, firstBad, f0;

    repeat (3) @(negedge clk);
    // R5: reset state of the pins and status
    check(codecRstN == 1'b0 && codecCsN == 1'b0 && codecSclk == 1'b1, "R5", "pins in reset",
          {codecRstN, codecCsN, codecSclk}, 3'b001);
    check(busy == 1'b1 && initDone == 1'b0 && done == 1'b0, "R5", "status in reset",
          {busy, initDone, done}, 3'b100);
    rstN = 1'b1;

    // R9: commands offered during power-on are refused
    accSeen = 0;
    cmdValid = 1'b1; cmdAddr = 7'h31; cmdData = 16'h00ab; cmdNoCache = 1'b0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      #1 if (cmdAccept) accSeen = 1;
    end
    cmdValid = 1'b0;

    while (!initDone && cyc < 20000) @(negedge clk);
    @(negedge clk);

    check(csUpCycles == RST_LOW, "R5", "select high before reset release", csUpCycles, RST_LOW);
    check(waitCycles == RST_WAIT, "R5", "wait before first frame", waitCycles, RST_WAIT);
    check(clockInReset == 0, "R5", "clock edges while reset low", clockInReset, 0);
    check(initCount == 30, "R6", "power-on frame count", initCount, 30);
    mism = 0; firstBad = 0;
    for (int i = 0; i < 30 && i < initCount; i++)
      if (initFrames[i] !== expInit(i)) begin
        if (mism == 0) firstBad = i;
        mism++;
      end
    check(mism == 0, "R6", "power-on frames in order",
          initFrames[firstBad], expInit(firstBad));
    check(doneInInit == 0, "R10", "done pulses during init", doneInInit, 0);
    check(accSeen == 0, "R9", "accept during power-on", accSeen, 0);
    readShadow(7'h31, sv);
    check(sv == 9'h000, "R9", "shadow of refused address", sv, 0);
    readShadow(7'h11, sv);
    check(sv == 9'h1ff, "R6", "shadow 0x11", sv, 9'h1ff);
    readShadow(7'h08, sv);
    check(sv == 9'h100, "R6", "shadow 0x08", sv, 9'h100);
    readShadow(7'h0a, sv);
    check(sv == 9'h0ff, "R6", "shadow 0x0a", sv, 9'h0ff);
    readShadow(7'h13, sv);
    check(sv == 9'h090, "R6", "shadow 0x13", sv, 9'h090);
    readShadow(7'h40, sv);
    check(sv == 9'h000, "R7", "unwritten shadow entry", sv, 0);

    // Vector table: R1, R2, R7, R8, R10
    for (int k = 0; k < NVEC; k++) begin
      @(negedge clk);
      while (busy) @(negedge clk);
      f0 = frames;
      cmdValid = 1'b1; cmdAddr = VEC[k][48:42]; cmdData = VEC[k][41:26]; cmdNoCache = VEC[k][25];
      #1 check(cmdAccept == 1'b1, "R9", "accept when idle", cmdAccept, 1);
      @(negedge clk);
      cmdValid = 1'b0;
      waitDone(lat, bad, wOk);
      check(bad == 1'b0 && lat < 2000, "R10", "done seen with busy low", {bad}, 0);
      check(wOk, "R10", "done lasts one cycle", wOk, 1);
      check(frames == f0 + 1 && lastFrame == VEC[k][24:9], "R1 R2", "frame on the wire",
            lastFrame, VEC[k][24:9]);
      rdAddr = VEC[k][48:42];
      #1 check(rdData == VEC[k][8:0], VEC[k][25] ? "R8" : "R7", "shadow after write",
               rdData, VEC[k][8:0]);
    end

    // R9: commands offered while a frame is in flight are refused
    @(negedge clk);
    f0 = frames;
    cmdValid = 1'b1; cmdAddr = 7'h34; cmdData = 16'h0011; cmdNoCache = 1'b0;
    @(negedge clk);
    cmdAddr = 7'h33; cmdData = 16'h0123;
    accSeen = 0;
    for (int i = 0; i < 20; i++) begin
      #1 if (cmdAccept) accSeen = 1;
      @(negedge clk);
    end
    cmdValid = 1'b0;
    waitDone(lat, bad, wOk);
    check(accSeen == 0, "R9", "accept while busy", accSeen, 0);
    repeat (200) @(negedge clk);
    check(frames == f0 + 1, "R9", "frames after busy offer", frames - f0, 1);
    check(lastFrame == {7'h34, 9'h011}, "R9", "only the accepted frame sent", lastFrame, {7'h34, 9'h011});
    readShadow(7'h33, sv);
    check(sv == 9'h000, "R9", "shadow of refused address", sv, 0);

    // Pin timing gathered over every frame: R2, R3, R4
    check(badBits == 0, "R2", "frames not 16 bits", badBits, 0);
    check(periodErr == 0, "R3", "serial clock period errors", periodErr, 0);
    check(holdErr == 0, "R3", "data changed while clock high", holdErr, 0);
    check(lagErr == 0, "R4", "select release lag errors", lagErr, 0);
    check(minGap >= 2 * CLK_DIV, "R4", "minimum select high gap", minGap, 2 * CLK_DIV);
    check(codecCsN == 1'b1 && codecSclk == 1'b1, "R4", "idle pins", {codecCsN, codecSclk}, 2'b11);

    finish_run();
  end

endmodule